// File: doc/BRIEF.md
# Mail Body Extraction Filter

This streaming filter sits on the byte path of a mail client and turns the raw text of one retrieved message into its body alone. Everything up to the first empty line is transport header text and is dropped. The following bytes are passed on until the line that holds only a period, which closes the message. That line and the line break in front of it are replaced by a single 0x00 byte, so software downstream receives a null-terminated string.

Both sides use valid/ready handshaking with a last flag. The filter needs no message buffer. A small matcher follows the closing sequence as the bytes arrive, and holds back the few bytes that could still belong to it. If the sequence fails to complete, the held bytes go out in their original order. A body line that starts with a doubled period has one period removed. If a message ends early, the string is still terminated and a truncation flag is raised. When the closing line is found before the input message ends, the rest of that input message is discarded. The filter then waits for the next message.

Top module: `mail_body_filter`

## Requirements
- R1: Every input byte up to and including the first occurrence of the four bytes 0x0D 0x0A 0x0D 0x0A is discarded. Partial or mixed runs of CR (0x0D) and LF (0x0A) in the header do not count as the separator.
- R2: After the separator, body bytes are forwarded in arrival order and unchanged, including lone CR, lone LF and line breaks that do not form the end sequence.
- R3: The body ends at the five bytes 0x0D 0x0A 0x2E 0x0D 0x0A. None of these bytes is forwarded. In their place a single 0x00 is output with out_last_o=1 and out_trunc_o=0. The separator's trailing CR LF counts as the leading CR LF of the end sequence, so a body that consists only of ".\r\n" gives just the 0x00 byte.
- R4: When a partial end sequence fails to complete, its held bytes are output in their original order before the byte that broke the match. If that breaking byte is a CR, it starts a new match.
- R5: When a body line (including the first body line) starts with 0x2E 0x2E, only one 0x2E is output and the rest of the line follows unchanged.
- R6: If in_last_i arrives before the end sequence completes, the bytes still held are output, followed by a 0x00 with out_last_o=1 and out_trunc_o=1. If in_last_i arrives during the header, only that 0x00 is output. The separator's implicit CR LF is never output.
- R7: After the end sequence, the remaining input bytes up to and including the one with in_last_i are discarded, and the next byte is treated as header text of a new message.
- R8: While out_valid_o=1 and out_ready_i=0, out_data_o, out_last_o and out_valid_o hold. No output byte is lost or repeated under any backpressure pattern.
- R9: After reset, out_valid_o=0 and in_ready_o=1.
- R10: out_last_o is asserted only on the 0x00 terminator beat, and out_trunc_o only together with out_last_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Filter accepts an input byte |
| in_data_i | input | 8 | Input message byte |
| in_last_i | input | 1 | Final byte of the input message |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream accepts the output byte |
| out_data_o | output | 8 | Output body byte or 0x00 terminator |
| out_last_o | output | 1 | This beat is the terminator |
| out_trunc_o | output | 1 | Terminator was forced by the end of input |

## Verification
Several message shapes are sent through the filter. A plain message checks that the header is dropped and the string is terminated. A header full of near-miss CR/LF runs shows whether the separator matcher resets correctly. Bodies containing lone CR, blank lines and ".x" lines show that non-matching line breaks pass intact. Messages that break the end sequence at its fourth and fifth byte, including with a fresh CR, check that held bytes are released in order. Doubled periods at the first body line and in later lines check dot removal. Messages cut short in the header, at the separator, and in the middle of a held match separate the three truncation paths. A message with trailing bytes followed by a second message checks discard and return to header mode. Two backpressure patterns show that bursts of released bytes are neither lost nor repeated.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
  localparam int BYTE_W    = 8;
  localparam int SEP_LEN   = 4;                 // CR LF CR LF
  localparam int MARK_LEN  = 5;                 // CR LF '.' CR LF
  localparam int VIRT_LEN  = 2;                 // leading CR LF implied by the separator
  localparam int STUFF_POS = MARK_LEN - 2;      // held prefix CR LF '.'
  localparam int Q_DEPTH   = MARK_LEN + 1;      // worst-case burst incl. terminator
  localparam int Q_CNT_W   = $clog2(Q_DEPTH + 1);
  localparam int SEP_W     = $clog2(SEP_LEN);
  localparam int MATCH_W   = $clog2(MARK_LEN + 1);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef byte_t [Q_DEPTH-1:0] burst_t;

  localparam byte_t CH_CR  = 8'h0D;
  localparam byte_t CH_LF  = 8'h0A;
  localparam byte_t CH_DOT = 8'h2E;
  localparam byte_t CH_NUL = 8'h00;

  typedef enum logic [1:0] {
    MODE_HDR,
    MODE_BODY,
    MODE_DRAIN
  } mode_e;
endpackage

// File: rtl/mbf_hdr_scan.sv
module mbf_hdr_scan
  import mbf_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  step_i,
  input  logic  last_i,
  input  byte_t data_i,
  output logic  found_o
);
  logic [SEP_W-1:0] pos_q, pos_d;
  byte_t            want;
  logic             at_end;

  // separator alternates CR / LF, so the parity of the position selects the byte
  always_comb begin
    want    = pos_q[0] ? CH_LF : CH_CR;
    at_end  = (pos_q == SEP_W'(SEP_LEN - 1));
    found_o = step_i && at_end && (data_i == want);
    if (data_i == want) pos_d = at_end ? '0 : pos_q + SEP_W'(1);
    else if (data_i == CH_CR) pos_d = SEP_W'(1);
    else pos_d = '0;
    if (last_i) pos_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pos_q <= '0;
    else if (step_i) pos_q <= pos_d;
  end
endmodule

// File: rtl/mbf_body_match.sv
module mbf_body_match
  import mbf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               step_i,
  input  logic               last_i,
  input  byte_t              data_i,
  output burst_t             burst_o,
  output logic [Q_CNT_W-1:0] cnt_o,
  output logic               term_o,
  output logic               trunc_o,
  output logic               end_o
);
  logic [MATCH_W-1:0] m_q, m_d;
  logic               virt_q, virt_d;
  logic hit, at_tail, keep, is_stuff, restart, flush;

  function automatic byte_t mark_byte(int idx);
    case (idx)
      0, 3:    return CH_CR;
      1, 4:    return CH_LF;
      default: return CH_DOT;
    endcase
  endfunction

  always_comb begin
    hit      = (data_i == mark_byte(int'(m_q)));
    at_tail  = (m_q == MATCH_W'(MARK_LEN - 1));
    end_o    = step_i && hit && at_tail;
    keep     = hit && !at_tail;
    is_stuff = !hit && (m_q == MATCH_W'(STUFF_POS)) && (data_i == CH_DOT);
    restart  = !hit && !is_stuff && (data_i == CH_CR);
    flush    = !hit && !is_stuff && !restart;

    burst_o = '0;
    cnt_o   = '0;
    term_o  = 1'b0;
    trunc_o = 1'b0;
    if (hit && at_tail) begin
      burst_o[0] = CH_NUL;
      cnt_o      = Q_CNT_W'(1);
      term_o     = 1'b1;
    end else begin
      if (!keep || last_i) begin
        for (int i = 0; i < MARK_LEN - 1; i++) begin
          if (i < int'(m_q) && !(virt_q && i < VIRT_LEN)) begin
            burst_o[cnt_o] = mark_byte(i);
            cnt_o          = cnt_o + Q_CNT_W'(1);
          end
        end
      end
      if ((flush || last_i) && !is_stuff) begin
        burst_o[cnt_o] = data_i;
        cnt_o          = cnt_o + Q_CNT_W'(1);
      end
      if (last_i) begin
        burst_o[cnt_o] = CH_NUL;
        cnt_o          = cnt_o + Q_CNT_W'(1);
        term_o         = 1'b1;
        trunc_o        = 1'b1;
      end
    end

    if (keep) m_d = m_q + MATCH_W'(1);
    else if (restart) m_d = MATCH_W'(1);
    else m_d = '0;
    virt_d = keep && virt_q;
    if (last_i || (hit && at_tail)) begin
      m_d    = '0;
      virt_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q    <= '0;
      virt_q <= 1'b0;
    end else if (start_i) begin
      m_q    <= MATCH_W'(VIRT_LEN);
      virt_q <= 1'b1;
    end else if (step_i) begin
      m_q    <= m_d;
      virt_q <= virt_d;
    end
  end
endmodule

// File: rtl/mbf_out_queue.sv
module mbf_out_queue
  import mbf_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  burst_t             burst_i,
  input  logic [Q_CNT_W-1:0] cnt_i,
  input  logic               term_i,
  input  logic               trunc_i,
  output logic               can_load_o,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output byte_t              out_data_o,
  output logic               out_last_o,
  output logic               out_trunc_o
);
  burst_t             q_q;
  logic [Q_CNT_W-1:0] cnt_q;
  logic               term_q, trunc_q, pop;

  assign out_valid_o = (cnt_q != '0);
  assign pop         = out_valid_o && out_ready_i;
  assign can_load_o  = (cnt_q == '0) || ((cnt_q == Q_CNT_W'(1)) && out_ready_i);
  assign out_data_o  = q_q[0];
  assign out_last_o  = out_valid_o && (cnt_q == Q_CNT_W'(1)) && term_q;
  assign out_trunc_o = out_last_o && trunc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_q     <= '0;
      cnt_q   <= '0;
      term_q  <= 1'b0;
      trunc_q <= 1'b0;
    end else if (load_i) begin
      q_q     <= burst_i;
      cnt_q   <= cnt_i;
      term_q  <= term_i;
      trunc_q <= trunc_i;
    end else if (pop) begin
      for (int i = 0; i < Q_DEPTH - 1; i++) q_q[i] <= q_q[i+1];
      q_q[Q_DEPTH-1] <= '0;
      cnt_q          <= cnt_q - Q_CNT_W'(1);
    end
  end
endmodule

// File: rtl/mail_body_filter.sv
module mail_body_filter
  import mbf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  output logic        in_ready_o,
  input  logic [7:0]  in_data_i,
  input  logic        in_last_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [7:0]  out_data_o,
  output logic        out_last_o,
  output logic        out_trunc_o
);
  mode_e              mode_q, mode_d;
  logic               in_fire, hdr_step, body_step, body_start, hdr_found;
  logic               in_hdr;
  burst_t             bm_burst, ld_burst;
  logic [Q_CNT_W-1:0] bm_cnt, ld_cnt;
  logic               bm_term, bm_trunc, bm_end, ld_term, ld_trunc;

  assign in_fire    = in_valid_i && in_ready_o;
  assign hdr_step   = in_fire && (mode_q == MODE_HDR);
  assign body_step  = in_fire && (mode_q == MODE_BODY);
  assign body_start = hdr_found && !in_last_i;
  assign in_hdr     = (mode_q == MODE_HDR);

  mbf_hdr_scan i_hdr_scan (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (hdr_step),
    .last_i  (in_last_i),
    .data_i  (in_data_i),
    .found_o (hdr_found)
  );

  mbf_body_match i_body_match (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (body_start),
    .step_i  (body_step),
    .last_i  (in_last_i),
    .data_i  (in_data_i),
    .burst_o (bm_burst),
    .cnt_o   (bm_cnt),
    .term_o  (bm_term),
    .trunc_o (bm_trunc),
    .end_o   (bm_end)
  );

  always_comb begin
    ld_burst = '0;
    ld_cnt   = '0;
    ld_term  = 1'b0;
    ld_trunc = 1'b0;
    mode_d   = mode_q;
    unique case (mode_q)
      MODE_HDR: begin
        if (in_last_i) begin
          ld_burst[0] = CH_NUL;
          ld_cnt      = Q_CNT_W'(1);
          ld_term     = 1'b1;
          ld_trunc    = 1'b1;
        end else if (hdr_found) begin
          mode_d = MODE_BODY;
        end
      end
      MODE_BODY: begin
        ld_burst = bm_burst;
        ld_cnt   = bm_cnt;
        ld_term  = bm_term;
        ld_trunc = bm_trunc;
        if (bm_end) mode_d = in_last_i ? MODE_HDR : MODE_DRAIN;
        else if (in_last_i) mode_d = MODE_HDR;
      end
      MODE_DRAIN: if (in_last_i) mode_d = MODE_HDR;
      default: mode_d = MODE_HDR;
    endcase
    if (!in_fire) mode_d = mode_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_HDR;
    else mode_q <= mode_d;
  end

  mbf_out_queue i_out_queue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (in_fire),
    .burst_i     (ld_burst),
    .cnt_i       (ld_cnt),
    .term_i      (ld_term),
    .trunc_i     (ld_trunc),
    .can_load_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .out_last_o  (out_last_o),
    .out_trunc_o (out_trunc_o)
  );
endmodule

// File: rtl/mail_body_filter_chk.sv
module mail_body_filter_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       in_valid_i,
  input logic       in_ready_o,
  input logic       in_last_i,
  input logic       out_valid_o,
  input logic       out_ready_i,
  input logic [7:0] out_data_o,
  input logic       out_last_o,
  input logic       out_trunc_o,
  input logic       hdr_mode_i
);
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));

  p_nul_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_last_o |-> out_data_o == 8'h00);

  p_trunc_last_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_trunc_o |-> out_valid_o && out_last_o);

  p_hdr_silent_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_mode_i && in_valid_i && in_ready_o && !in_last_i |=> !out_valid_o);

  p_idle_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);
endmodule

bind mail_body_filter mail_body_filter_chk i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_last_i   (in_last_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o),
  .out_trunc_o (out_trunc_o),
  .hdr_mode_i  (in_hdr)
);

// File: tb/test_mail_body_filter.sv
module test_mail_body_filter;
  logic       clk, rst_n;
  logic       in_valid, in_ready, in_last;
  logic [7:0] in_data;
  logic       out_valid, out_ready, out_last, out_trunc;
  logic [7:0] out_data;
  int         n_checks = 0;
  int         n_err = 0;

  mail_body_filter i_mail_body_filter (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .in_valid_i  (in_valid),
    .in_ready_o  (in_ready),
    .in_data_i   (in_data),
    .in_last_i   (in_last),
    .out_valid_o (out_valid),
    .out_ready_i (out_ready),
    .out_data_o  (out_data),
    .out_last_o  (out_last),
    .out_trunc_o (out_trunc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // '|' = CR LF, '^' = lone CR, '~' = lone LF
  function automatic string expand(string s);
    string r = "";
    for (int i = 0; i < s.len(); i++) begin
      if (s[i] == "|") r = {r, $sformatf("%c%c", 8'h0D, 8'h0A)};
      else if (s[i] == "^") r = {r, $sformatf("%c", 8'h0D)};
      else if (s[i] == "~") r = {r, $sformatf("%c", 8'h0A)};
      else r = {r, $sformatf("%c", s[i])};
    end
    return r;
  endfunction

  function automatic string show(string s);
    string r = "";
    for (int i = 0; i < s.len(); i++) begin
      if (s[i] == 8'h0D) r = {r, "<CR>"};
      else if (s[i] == 8'h0A) r = {r, "<LF>"};
      else r = {r, $sformatf("%c", s[i])};
    end
    return r;
  endfunction

  task automatic check_str(string req, string what, string act, string exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual \"%s\" expected \"%s\"", req, what, show(act), show(exp));
    end
  endtask

  task automatic check_val(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_msg(string req, string msg_raw, string exp_raw, bit exp_trunc, int bp);
    string msg = expand(msg_raw);
    string exp = expand(exp_raw);
    string got = "";
    int    term_b = -1;
    int    got_trunc = -1;
    fork
      begin
        for (int i = 0; i < msg.len(); i++) begin
          @(negedge clk);
          in_valid = 1'b1;
          in_data  = msg[i];
          in_last  = (i == msg.len() - 1);
          #1;
          while (!in_ready) begin
            @(negedge clk);
            #1;
          end
          @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
      begin
        bit done = 1'b0;
        int phase = 0;
        while (!done) begin
          @(negedge clk);
          out_ready = (bp == 0) || (phase % (bp + 1) == 0);
          phase++;
          #1;
          if (out_valid && out_ready) begin
            if (out_last) begin
              done      = 1'b1;
              term_b    = int'(out_data);
              got_trunc = int'(out_trunc);
            end else begin
              got = {got, $sformatf("%c", out_data)};
            end
          end
        end
      end
    join
    check_str(req, "body text", got, exp);
    check_val("R10", "terminator byte", term_b, 0);
    check_val(exp_trunc ? "R6" : "R3", "trunc flag", got_trunc, int'(exp_trunc));
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check_val("R9", "out_valid after reset", int'(out_valid), 0);
    check_val("R9", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_basic();
    run_msg("R1", "Subj: a|From: b||Hello|.|", "Hello", 1'b0, 0);
  endtask

  task automatic t_header_near_miss();
    run_msg("R1", "A|~B^||body|.|", "body", 1'b0, 0);
  endtask

  task automatic t_body_breaks();
    run_msg("R2", "A|^|B||ab^c|line2|||.x|.|", "ab^c|line2|||.x", 1'b0, 0);
  endtask

  task automatic t_dot_stuff();
    run_msg("R5", "H||..dot|z|..|a|.|", ".dot|z|.|a", 1'b0, 0);
  endtask

  task automatic t_empty_body();
    run_msg("R3", "H||.|", "", 1'b0, 0);
  endtask

  task automatic t_miss_tail();
    run_msg("R4", "H||A|.^X|.|", "A|.^X", 1'b0, 0);
  endtask

  task automatic t_miss_restart();
    run_msg("R4", "H||A|.^|.|", "A|.^", 1'b0, 0);
  endtask

  task automatic t_drain_then_next();
    run_msg("R7", "H||A|.|JUNK||more", "A", 1'b0, 2);
    run_msg("R7", "X: y||Next|.|", "Next", 1'b0, 0);
  endtask

  task automatic t_trunc_body();
    run_msg("R6", "H||abc|.", "abc|.", 1'b1, 0);
  endtask

  task automatic t_trunc_header();
    run_msg("R6", "Subj only|", "", 1'b1, 0);
  endtask

  task automatic t_trunc_at_sep();
    run_msg("R6", "H||", "", 1'b1, 0);
  endtask

  task automatic t_trunc_virtual();
    run_msg("R6", "H||.", ".", 1'b1, 0);
  endtask

  task automatic t_backpressure();
    run_msg("R8", "H: v||q|..r|w^|.^Z|.|", "q|.r|w^|.^Z", 1'b0, 1);
    run_msg("R8", "H||x|.^^|.|", "x|.^^", 1'b0, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    in_valid  = 1'b0;
    in_last   = 1'b0;
    in_data   = 8'h00;
    out_ready = 1'b1;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_header_near_miss();
    t_body_breaks();
    t_dot_stuff();
    t_empty_body();
    t_miss_tail();
    t_miss_restart();
    t_drain_then_next();
    t_trunc_body();
    t_trunc_header();
    t_trunc_at_sep();
    t_trunc_virtual();
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule